// File: doc/BRIEF.md
# Keyed Indexed Configuration Port

This block guards a bank of configuration registers behind two adjacent host I/O addresses: an index port and a data port one address above it. After reset the port is closed. The host opens it by writing the entry key 83h to the index port twice in a row, and closes it again by writing AAh there. While the port is open, each other byte written to the index port names a register, and the data port reads or writes that register.

Registers below 30h are global. Registers from 30h upward exist once per logical device (four by default). The device is chosen by the device-select register at 07h. A strap input is sampled while reset is held. It decides which address pair the block answers on, and it sets the reset value of a port-select bit that the host may later rewrite. A lock bit, once set, shuts off all data-port access until the next hardware reset.

The host bus is a plain single-cycle strobe interface. A write or read takes effect at the clock edge that samples its strobe. Read data is registered and valid from the following cycle. There is no back-pressure: every access completes at once and no stall is ever signalled.

Top module: `cfg_port`

## Requirements
- R1: After reset the port is closed, io_rdata is 00h, and a data-port read returns FFh.
- R2: The port opens only after two consecutive index-port writes of 83h. Any other index-port write while not yet open returns the key sequence to its start.
- R3: While the port is open, an index-port write of AAh closes it. While closed, data-port writes change no register, and index-port writes do not change the selected index.
- R4: While the port is open, an index-port write (other than AAh) selects a register, and later data-port accesses use it. An index-port read returns FFh. A read at any other address leaves io_rdata unchanged.
- R5: Register 20h reads 71h and register 21h reads 1<REV>h (10h by default). Writes to either have no effect.
- R6: Register 22h resets to 80h, and only bits 7:5 are writable. Register 23h resets to 00h, and only bits 7:4 are writable. Other bits read 0.
- R7: Register 07h holds the device number in its low 2 bits; upper bits read 0. Registers 30h (bit 0), 60h, 61h, 70h (bits 3:0) and F0h are kept separately for each device and reset to 00h.
- R8: With strap=1 at reset release, the ports are 2Eh/2Fh and register 26h bit 6 reads 0. With strap=0, the ports are 4Eh/4Fh and bit 6 reads 1. Writing bit 6 moves the ports to the other pair from the next access on.
- R9: Writing 1 to register 26h bit 5 locks the block. From then until hardware reset, data-port reads return FFh and data-port writes are ignored.
- R10: Writing a byte with bit 0 set to register 02h returns every global and per-device register to its reset value, with bit 6 of 26h taken from the latched strap. The port stays open, and 02h reads 00h.
- R11: Any index with no register reads 00h, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; strap is sampled while low |
| strap | input | 1 | Port-pair strap, latched at reset release |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_rd | input | 1 | Host read strobe, one cycle per access |
| io_addr | input | 8 | Host I/O address offset |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Registered read data, valid the cycle after io_rd |

## Verification
The assertions assume that strap does not change while the block is out of reset, and that io_wr and io_rd are never high in the same cycle. The bench drives strap only around reset pulses, and it issues exactly one strobe per access, so both assumptions hold.

The random phase never sets the lock bit, so it keeps running for its whole length. The lock is tested only in directed steps, each followed by a hardware reset. Random traffic does mix the key bytes, the exit byte, port-pair changes and software resets into ordinary register traffic.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;

  localparam logic [7:0] IX_SWRST   = 8'h02;
  localparam logic [7:0] IX_LDN     = 8'h07;
  localparam logic [7:0] IX_ID_HI   = 8'h20;
  localparam logic [7:0] IX_ID_LO   = 8'h21;
  localparam logic [7:0] IX_PWR     = 8'h22;
  localparam logic [7:0] IX_PME     = 8'h23;
  localparam logic [7:0] IX_CTRL    = 8'h26;
  localparam logic [7:0] IX_BANK_LO = 8'h30;
  localparam logic [7:0] IX_ACT     = 8'h30;
  localparam logic [7:0] IX_BASE_HI = 8'h60;
  localparam logic [7:0] IX_BASE_LO = 8'h61;
  localparam logic [7:0] IX_IRQ     = 8'h70;
  localparam logic [7:0] IX_OPT     = 8'hF0;

  typedef struct packed {
    logic       act;
    logic [7:0] base_hi;
    logic [7:0] base_lo;
    logic [3:0] irq;
    logic [7:0] opt;
  } bank_t;
endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import cfg_pkg::*;
#(
  parameter logic [7:0] KEY_ENTER = 8'h83,
  parameter logic [7:0] KEY_EXIT  = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       open_o,
  output logic       half_o
);
  key_state_e st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= KS_LOCKED;
    end else if (idx_wr) begin
      case (st)
        KS_LOCKED: st <= (wdata == KEY_ENTER) ? KS_HALF : KS_LOCKED;
        KS_HALF:   st <= (wdata == KEY_ENTER) ? KS_OPEN : KS_LOCKED;
        KS_OPEN:   if (wdata == KEY_EXIT) st <= KS_LOCKED;
        default:   st <= KS_LOCKED;
      endcase
    end
  end

  assign open_o = (st == KS_OPEN);
  assign half_o = (st == KS_HALF);
endmodule

// File: rtl/cfg_global.sv
module cfg_global
  import cfg_pkg::*;
#(
  parameter int         LDN_W = 2,
  parameter logic [7:0] ID_HI = 8'h71,
  parameter logic [7:0] ID_LO = 8'h10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap,
  input  logic             hef_dflt,
  input  logic             clr,
  input  logic             we,
  input  logic [7:0]       idx,
  input  logic [7:0]       wdata,
  output logic [LDN_W-1:0] ldn,
  output logic             hefras,
  output logic             lock,
  output logic [7:0]       rdata
);
  logic [2:0] pd_n;
  logic [3:0] pme;
  logic       unused_bits;

  assign unused_bits = ^wdata[3:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ldn    <= '0;
      pd_n   <= 3'b100;
      pme    <= '0;
      hefras <= ~strap;
      lock   <= 1'b0;
    end else if (clr) begin
      ldn    <= '0;
      pd_n   <= 3'b100;
      pme    <= '0;
      hefras <= hef_dflt;
    end else if (we) begin
      case (idx)
        IX_LDN:  ldn  <= wdata[LDN_W-1:0];
        IX_PWR:  pd_n <= wdata[7:5];
        IX_PME:  pme  <= wdata[7:4];
        IX_CTRL: begin
          hefras <= wdata[6];
          lock   <= wdata[5];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      IX_LDN:   rdata = {{(8-LDN_W){1'b0}}, ldn};
      IX_ID_HI: rdata = ID_HI;
      IX_ID_LO: rdata = ID_LO;
      IX_PWR:   rdata = {pd_n, 5'b0};
      IX_PME:   rdata = {pme, 4'b0};
      IX_CTRL:  rdata = {1'b0, hefras, lock, 5'b0};
      default:  rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       we,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  bank_t r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r <= '0;
    end else if (clr) begin
      r <= '0;
    end else if (we) begin
      case (idx)
        IX_ACT:     r.act     <= wdata[0];
        IX_BASE_HI: r.base_hi <= wdata;
        IX_BASE_LO: r.base_lo <= wdata;
        IX_IRQ:     r.irq     <= wdata[3:0];
        IX_OPT:     r.opt     <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      IX_ACT:     rdata = {7'b0, r.act};
      IX_BASE_HI: rdata = r.base_hi;
      IX_BASE_LO: rdata = r.base_lo;
      IX_IRQ:     rdata = {4'b0, r.irq};
      IX_OPT:     rdata = r.opt;
      default:    rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/cfg_port.sv
module cfg_port
  import cfg_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                NUM_DEV   = 4,
  parameter logic [ADDR_W-1:0] PORT_A    = 8'h2E,
  parameter logic [ADDR_W-1:0] PORT_B    = 8'h4E,
  parameter logic [7:0]        KEY_ENTER = 8'h83,
  parameter logic [7:0]        KEY_EXIT  = 8'hAA,
  parameter logic [7:0]        ID_HI     = 8'h71,
  parameter logic [3:0]        REV       = 4'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata
);
  localparam int         LDN_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam logic [7:0] ID_LO = {4'h1, REV};

  logic              strap_q;
  logic              hefras, lock, cfg_open, cfg_half;
  logic [LDN_W-1:0]  ldn;
  logic [ADDR_W-1:0] idx_port, dat_port;
  logic              idx_wr, dat_wr, dat_rd, idx_rd, reg_we, sw_clr;
  logic [7:0]        index_q, glob_rd, sel_bank;
  logic [7:0]        bank_rd [NUM_DEV];

  // Strap follows the pin while reset is held, freezes at release
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap;
  end

  assign idx_port = hefras ? PORT_B : PORT_A;
  assign dat_port = idx_port + ADDR_W'(1);
  assign idx_wr   = io_wr && (io_addr == idx_port);
  assign idx_rd   = io_rd && (io_addr == idx_port);
  assign dat_wr   = io_wr && (io_addr == dat_port);
  assign dat_rd   = io_rd && (io_addr == dat_port);
  assign reg_we   = dat_wr && cfg_open && !lock;
  assign sw_clr   = reg_we && (index_q == IX_SWRST) && io_wdata[0];

  cfg_key_fsm #(.KEY_ENTER(KEY_ENTER), .KEY_EXIT(KEY_EXIT)) u_key (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(io_wdata),
    .open_o(cfg_open), .half_o(cfg_half)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) index_q <= 8'h00;
    else if (idx_wr && cfg_open && (io_wdata != KEY_EXIT)) index_q <= io_wdata;
  end

  cfg_global #(.LDN_W(LDN_W), .ID_HI(ID_HI), .ID_LO(ID_LO)) u_glob (
    .clk(clk), .rst_n(rst_n), .strap(strap), .hef_dflt(~strap_q),
    .clr(sw_clr), .we(reg_we && (index_q < IX_BANK_LO)), .idx(index_q),
    .wdata(io_wdata), .ldn(ldn), .hefras(hefras), .lock(lock), .rdata(glob_rd)
  );

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_bank
    cfg_bank u_bank (
      .clk(clk), .rst_n(rst_n), .clr(sw_clr),
      .we(reg_we && (index_q >= IX_BANK_LO) && (ldn == LDN_W'(g))),
      .idx(index_q), .wdata(io_wdata), .rdata(bank_rd[g])
    );
  end

  assign sel_bank = bank_rd[ldn];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_rdata <= 8'h00;
    end else if (idx_rd) begin
      io_rdata <= 8'hFF;
    end else if (dat_rd) begin
      if (!cfg_open || lock)          io_rdata <= 8'hFF;
      else if (index_q >= IX_BANK_LO) io_rdata <= sel_bank;
      else                            io_rdata <= glob_rd;
    end
  end
endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk #(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] PORT_A    = 8'h2E,
  parameter logic [ADDR_W-1:0] PORT_B    = 8'h4E,
  parameter logic [7:0]        KEY_ENTER = 8'h83,
  parameter logic [7:0]        KEY_EXIT  = 8'hAA
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_wr,
  input logic              io_rd,
  input logic [ADDR_W-1:0] io_addr,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              open_i,
  input logic              half_i,
  input logic              lock_i,
  input logic              hefras_i
);
  logic [ADDR_W-1:0] ip, dp;
  assign ip = hefras_i ? PORT_B : PORT_A;
  assign dp = ip + ADDR_W'(1);

  p_open_needs_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (open_i && !$past(open_i)) |->
      ($past(half_i) && $past(io_wr) && ($past(io_wdata) == KEY_ENTER)));

  p_exit_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (open_i && io_wr && (io_addr == ip) && (io_wdata == KEY_EXIT)) |=> !open_i);

  p_closed_read_ff_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && (io_addr == dp) && !open_i) |=> (io_rdata == 8'hFF));

  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i |=> lock_i);

  p_ports_frozen_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !open_i |=> $stable(hefras_i));

  p_idx_read_ff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && (io_addr == ip)) |=> (io_rdata == 8'hFF));
endmodule

bind cfg_port cfg_port_chk #(
  .ADDR_W(ADDR_W), .PORT_A(PORT_A), .PORT_B(PORT_B),
  .KEY_ENTER(KEY_ENTER), .KEY_EXIT(KEY_EXIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .open_i(cfg_open),
  .half_i(cfg_half), .lock_i(lock), .hefras_i(hefras)
);

// File: tb/sim_cfg_port.sv
module sim_cfg_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap = 1'b1;
  logic       io_wr = 1'b0;
  logic       io_rd = 1'b0;
  logic [7:0] io_addr = 8'h00;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cfg_port u0 (
    .clk(clk), .rst_n(rst_n), .strap(strap), .io_wr(io_wr), .io_rd(io_rd),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata)
  );

  // ---------------- reference model built from the requirements
  int         m_state;
  logic [7:0] m_idx, m_rdata;
  logic [1:0] m_ldn;
  logic [2:0] m_pd;
  logic [3:0] m_pme;
  logic       m_hef, m_lock, m_strap;
  logic       m_act [4];
  logic [7:0] m_bhi [4];
  logic [7:0] m_blo [4];
  logic [3:0] m_irq [4];
  logic [7:0] m_opt [4];

  task automatic m_defaults();
    m_ldn = 2'd0; m_pd = 3'b100; m_pme = 4'h0; m_hef = ~m_strap;
    for (int i = 0; i < 4; i++) begin
      m_act[i] = 1'b0; m_bhi[i] = 8'h00; m_blo[i] = 8'h00;
      m_irq[i] = 4'h0; m_opt[i] = 8'h00;
    end
  endtask

  function automatic logic [7:0] m_reg(input logic [7:0] ix);
    case (ix)
      8'h07: return {6'b0, m_ldn};
      8'h20: return 8'h71;
      8'h21: return 8'h10;
      8'h22: return {m_pd, 5'b0};
      8'h23: return {m_pme, 4'b0};
      8'h26: return {1'b0, m_hef, m_lock, 5'b0};
      8'h30: return {7'b0, m_act[m_ldn]};
      8'h60: return m_bhi[m_ldn];
      8'h61: return m_blo[m_ldn];
      8'h70: return {4'b0, m_irq[m_ldn]};
      8'hF0: return m_opt[m_ldn];
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_reg_write(input logic [7:0] ix, input logic [7:0] d);
    case (ix)
      8'h02: if (d[0]) m_defaults();
      8'h07: m_ldn = d[1:0];
      8'h22: m_pd = d[7:5];
      8'h23: m_pme = d[7:4];
      8'h26: begin m_hef = d[6]; m_lock = d[5]; end
      8'h30: m_act[m_ldn] = d[0];
      8'h60: m_bhi[m_ldn] = d;
      8'h61: m_blo[m_ldn] = d;
      8'h70: m_irq[m_ldn] = d[3:0];
      8'hF0: m_opt[m_ldn] = d;
      default: ;
    endcase
  endtask

  task automatic m_write(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] ip;
    ip = m_hef ? 8'h4E : 8'h2E;
    if (a == ip) begin
      case (m_state)
        0: m_state = (d == 8'h83) ? 1 : 0;
        1: m_state = (d == 8'h83) ? 2 : 0;
        default: if (d == 8'hAA) m_state = 0; else m_idx = d;
      endcase
    end else if (a == ip + 8'd1 && m_state == 2 && !m_lock) begin
      m_reg_write(m_idx, d);
    end
  endtask

  function automatic logic [7:0] m_read(input logic [7:0] a);
    logic [7:0] ip;
    ip = m_hef ? 8'h4E : 8'h2E;
    if (a == ip) return 8'hFF;
    if (a == ip + 8'd1) return (m_state != 2 || m_lock) ? 8'hFF : m_reg(m_idx);
    return m_rdata;
  endfunction

  // ---------------- bus tasks
  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 1'b0; strap = s; io_wr = 1'b0; io_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_strap = s; m_state = 0; m_idx = 8'h00; m_rdata = 8'h00; m_lock = 1'b0;
    m_defaults();
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
    m_write(a, d);
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // read, compare to literal expectation and keep model rdata in step
  task automatic rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    io_rd = 1'b1; io_addr = a;
    @(negedge clk);
    io_rd = 1'b0;
    m_rdata = m_read(a);
    chk(tag, io_rdata, exp);
  endtask

  task automatic rd_model(input string tag, input logic [7:0] a);
    rd(tag, a, m_read(a));
  endtask

  task automatic open_port(input logic [7:0] ip);
    wr(ip, 8'h83); wr(ip, 8'h83);
  endtask

  task automatic put(input logic [7:0] ip, input logic [7:0] ix, input logic [7:0] d);
    wr(ip, ix); wr(ip + 8'd1, d);
  endtask

  task automatic get(input string tag, input logic [7:0] ip, input logic [7:0] ix,
                     input logic [7:0] exp);
    wr(ip, ix); rd(tag, ip + 8'd1, exp);
  endtask

  function automatic logic [7:0] pick_data(input int k);
    case (k)
      0, 1: return 8'h83;
      2:  return 8'hAA;
      3:  return 8'h07;
      4:  return 8'h02;
      5:  return 8'h20;
      6:  return 8'h21;
      7:  return 8'h22;
      8:  return 8'h23;
      9:  return 8'h26;
      10: return 8'h30;
      11: return 8'h60;
      12: return 8'h61;
      13: return 8'h70;
      14: return 8'hF0;
      default: return 8'($urandom);
    endcase
  endfunction

  // ---------------- watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] a, d;
    void'($urandom(32'd2718));

    // ---- strap=1: ports 2E/2F
    do_reset(1'b1);
    chk("R1 rdata after reset", io_rdata, 8'h00);
    rd("R1 closed data read", 8'h2F, 8'hFF);

    // broken key sequences
    wr(8'h2E, 8'h83); wr(8'h2E, 8'h12); wr(8'h2E, 8'h83); wr(8'h2E, 8'h20);
    rd("R2 broken key keeps closed", 8'h2F, 8'hFF);

    open_port(8'h2E);
    get("R5 id high", 8'h2E, 8'h20, 8'h71);
    wr(8'h2F, 8'h55);
    rd("R5 id high write ignored", 8'h2F, 8'h71);
    get("R5 id low", 8'h2E, 8'h21, 8'h10);
    rd("R4 index port read", 8'h2E, 8'hFF);
    rd("R4 other address read unchanged", 8'h10, 8'hFF);

    get("R8 strap1 select bit", 8'h2E, 8'h26, 8'h00);
    get("R6 power reg reset", 8'h2E, 8'h22, 8'h80);
    wr(8'h2F, 8'hFF);
    rd("R6 power reg mask", 8'h2F, 8'hE0);
    put(8'h2E, 8'h23, 8'hFF);
    rd("R6 pme reg mask", 8'h2F, 8'hF0);

    put(8'h2E, 8'h05, 8'h5A);
    rd("R11 undefined index", 8'h2F, 8'h00);
    get("R11 undefined 2Ah", 8'h2E, 8'h2A, 8'h00);

    put(8'h2E, 8'h07, 8'h01); put(8'h2E, 8'h60, 8'h12);
    get("R7 bank default dev1 61h", 8'h2E, 8'h61, 8'h00);
    put(8'h2E, 8'h07, 8'h02); put(8'h2E, 8'h60, 8'h34);
    put(8'h2E, 8'h07, 8'h01);
    get("R7 dev1 base", 8'h2E, 8'h60, 8'h12);
    put(8'h2E, 8'h07, 8'h02);
    get("R7 dev2 base", 8'h2E, 8'h60, 8'h34);
    put(8'h2E, 8'h07, 8'h05);
    get("R7 ldn low bits", 8'h2E, 8'h07, 8'h01);
    get("R7 ldn wrap selects dev1", 8'h2E, 8'h60, 8'h12);
    put(8'h2E, 8'h70, 8'hFF);
    rd("R7 irq nibble", 8'h2F, 8'h0F);

    put(8'h2E, 8'h02, 8'h01);
    rd("R10 swrst reads zero", 8'h2F, 8'h00);
    get("R10 power reg restored", 8'h2E, 8'h22, 8'h80);
    get("R10 ldn restored", 8'h2E, 8'h07, 8'h00);
    put(8'h2E, 8'h07, 8'h01);
    get("R10 bank cleared", 8'h2E, 8'h60, 8'h00);

    // exit, locked writes ignored, index retained
    put(8'h2E, 8'h22, 8'hC0);
    wr(8'h2E, 8'hAA);
    rd("R3 exit closes", 8'h2F, 8'hFF);
    wr(8'h2F, 8'h00);
    wr(8'h2E, 8'h23);
    open_port(8'h2E);
    rd("R3 closed write ignored", 8'h2F, 8'hC0);

    // port pair switch
    put(8'h2E, 8'h26, 8'h40);
    rd("R8 moved to 4F", 8'h4F, 8'h40);
    rd("R8 old pair ignored", 8'h2F, 8'h40);
    put(8'h4E, 8'h26, 8'h00);
    rd("R8 back at 2F", 8'h2F, 8'h00);

    // lock
    put(8'h2E, 8'h26, 8'h20);
    rd("R9 locked read", 8'h2F, 8'hFF);
    wr(8'h2E, 8'h22); wr(8'h2F, 8'h00);
    wr(8'h2E, 8'hAA); open_port(8'h2E);
    rd("R9 lock survives exit", 8'h2F, 8'hFF);

    // ---- strap=0: ports 4E/4F
    do_reset(1'b0);
    rd("R1 closed at 4F", 8'h4F, 8'hFF);
    open_port(8'h2E);
    rd("R8 keys at 2E ignored", 8'h4F, 8'hFF);
    open_port(8'h4E);
    get("R8 strap0 select bit", 8'h4E, 8'h26, 8'h40);
    put(8'h4E, 8'h26, 8'h00);
    put(8'h2E, 8'h02, 8'h01);
    get("R10 swrst reloads strap", 8'h4E, 8'h26, 8'h40);

    // ---- random traffic against the model (lock bit never set)
    do_reset(1'b1);
    for (int i = 0; i < 3000; i++) begin
      int sel;
      sel = int'($urandom % 5);
      case (sel)
        0: a = 8'h2E;
        1: a = 8'h2F;
        2: a = 8'h4E;
        3: a = 8'h4F;
        default: a = 8'h10;
      endcase
      if (($urandom % 3) == 0) begin
        rd_model("R4 random read vs model", a);
      end else begin
        d = pick_data(int'($urandom % 18));
        if (a == (m_hef ? 8'h4F : 8'h2F) && m_idx == 8'h26) d[5] = 1'b0;
        wr(a, d);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule